// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves the relative jump format of a 16-bit CPU. It takes the instruction word and the program counter, which already points at the word after the jump. It also takes the status register. From these it decides whether the word is a jump, whether the branch is taken, and what the next program counter is. A taken branch adds a signed word offset to the program counter. The offset is doubled so that it becomes a byte displacement.

Control and datapath are split into two modules. The control module decodes the format and evaluates one of eight conditions against the carry, zero, negative and overflow flags. It hands the datapath two strobes, one meaning "this is a jump" and one meaning "take it". The datapath sign-extends the offset, forms the target and selects the next PC. The parameter `PipeOut` sets the output stage. With the default value 1, all three results are registered and appear one clock after their inputs. With 0, the outputs are combinational.

Top module: `brUnit`

## Requirements
- R1: A word is a jump exactly when bits 15:13 equal 3'b001. `isJump` reports this, and `taken` is never high unless `isJump` is high.
- R2: The condition code is instruction bits 12:10. Code 0 branches when Z (status bit 1) is clear. Code 1 branches when Z is set. Code 2 branches when C (status bit 0) is clear. Code 3 branches when C is set.
- R3: Code 4 branches when N (status bit 2) is set. Code 7 branches regardless of the status register.
- R4: Code 5 branches when N and V (status bit 8) are equal. Code 6 branches when N and V differ.
- R5: When taken, the next PC is `pcIn` plus the displacement, wrapped modulo 2^16. The displacement is bits 9:0 sign-extended from bit 9 and multiplied by two, which gives -1024 to +1022 bytes.
- R6: A jump that is not taken gives `nextPc` equal to `pcIn`.
- R7: A word that is not a jump gives `isJump` = 0, `taken` = 0 and `nextPc` equal to `pcIn`, whatever the status register holds.
- R8: With `PipeOut` = 1, every output reflects the inputs sampled at the previous rising clock edge. While `rstN` is low, the outputs are held at zero.
- R9: Status bits other than 0, 1, 2 and 8 have no effect on any output.
- R10: A taken target always has bit 0 cleared, even when `pcIn` is odd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| instrWord | input | 16 | Instruction word under evaluation |
| pcIn | input | 16 | Program counter already advanced past the instruction |
| statusIn | input | 16 | Status register (C bit 0, Z bit 1, N bit 2, V bit 8) |
| isJump | output | 1 | Word has the jump format |
| taken | output | 1 | Branch condition met |
| nextPc | output | 16 | Program counter to use next |

## Verification
With the default registered stage, all three results are due exactly one rising edge after the inputs are applied. The bench therefore drives inputs on a falling edge, lets one rising edge pass, and samples on the following falling edge. No result is ever read on the edge that captures it. The reset checks sample a full cycle after `rstN` changes, so the synchronous clear has been taken. The checker compares each registered output with the inputs of the previous cycle through `$past`. It arms itself only once one clock has passed out of reset.

// File: rtl/brPkg.sv
package brPkg;
  localparam int InstrW = 16;
  localparam int PcW = 16;
  localparam int OffW = 10;
  localparam int CondW = 3;
  localparam int CondLsb = OffW;
  localparam int FmtLsb = CondLsb + CondW;
  localparam int FmtW = InstrW - FmtLsb;
  localparam logic [FmtW-1:0] JumpFmt = 3'b001;

  localparam int FlagC = 0;
  localparam int FlagZ = 1;
  localparam int FlagN = 2;
  localparam int FlagV = 8;

  typedef enum logic [CondW-1:0] {
    CondNotZero  = 3'd0,
    CondZero     = 3'd1,
    CondNoCarry  = 3'd2,
    CondCarry    = 3'd3,
    CondNeg      = 3'd4,
    CondGe       = 3'd5,
    CondLt       = 3'd6,
    CondAlways   = 3'd7
  } condCode_e;

  typedef struct packed {
    logic isJump;
    logic takeBranch;
  } brStrobes_t;
endpackage

// File: rtl/brCtrl.sv
module brCtrl
  import brPkg::*;
(
  input  logic [InstrW-1:0] instrWord,
  input  logic [PcW-1:0]    statusIn,
  output brStrobes_t        strobes
);
  logic fmtMatch;
  logic condMet;
  logic flagC, flagZ, flagN, flagV;
  condCode_e cond;

  assign fmtMatch = (instrWord[InstrW-1:FmtLsb] == JumpFmt);
  assign cond     = condCode_e'(instrWord[CondLsb +: CondW]);
  assign flagC    = statusIn[FlagC];
  assign flagZ    = statusIn[FlagZ];
  assign flagN    = statusIn[FlagN];
  assign flagV    = statusIn[FlagV];

  always_comb begin
    unique case (cond)
      CondNotZero: condMet = !flagZ;
      CondZero:    condMet = flagZ;
      CondNoCarry: condMet = !flagC;
      CondCarry:   condMet = flagC;
      CondNeg:     condMet = flagN;
      CondGe:      condMet = !(flagN ^ flagV);
      CondLt:      condMet = flagN ^ flagV;
      CondAlways:  condMet = 1'b1;
      default:     condMet = 1'b0;
    endcase
  end

  assign strobes.isJump     = fmtMatch;
  assign strobes.takeBranch = fmtMatch && condMet;
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter bit PipeOut = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [InstrW-1:0] instrWord,
  input  logic [PcW-1:0]    pcIn,
  input  brStrobes_t        strobes,
  output logic              isJump,
  output logic              taken,
  output logic [PcW-1:0]    nextPc
);
  localparam int ExtW = PcW - OffW - 1;

  logic [OffW-1:0] wordOff;
  logic [PcW-1:0]  byteDisp;
  logic [PcW-1:0]  targetSum;
  logic [PcW-1:0]  targetPc;
  logic [PcW-1:0]  pcSel;

  assign wordOff   = instrWord[OffW-1:0];
  assign byteDisp  = {{ExtW{wordOff[OffW-1]}}, wordOff, 1'b0};
  assign targetSum = pcIn + byteDisp;
  assign targetPc  = {targetSum[PcW-1:1], 1'b0};
  assign pcSel     = strobes.takeBranch ? targetPc : pcIn;

  generate
    if (PipeOut) begin : g_reg
      logic           jumpQ;
      logic           takenQ;
      logic [PcW-1:0] pcQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          jumpQ  <= 1'b0;
          takenQ <= 1'b0;
          pcQ    <= '0;
        end else begin
          jumpQ  <= strobes.isJump;
          takenQ <= strobes.takeBranch;
          pcQ    <= pcSel;
        end
      end
      assign isJump = jumpQ;
      assign taken  = takenQ;
      assign nextPc = pcQ;
    end else begin : g_comb
      assign isJump = strobes.isJump;
      assign taken  = strobes.takeBranch;
      assign nextPc = pcSel;
    end
  endgenerate
endmodule

// File: rtl/brUnit.sv
module brUnit
  import brPkg::*;
#(
  parameter bit PipeOut = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [InstrW-1:0] instrWord,
  input  logic [PcW-1:0]    pcIn,
  input  logic [PcW-1:0]    statusIn,
  output logic              isJump,
  output logic              taken,
  output logic [PcW-1:0]    nextPc
);
  brStrobes_t strobes;

  brCtrl uCtrl (
    .instrWord (instrWord),
    .statusIn  (statusIn),
    .strobes   (strobes)
  );

  brDatapath #(.PipeOut(PipeOut)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .pcIn      (pcIn),
    .strobes   (strobes),
    .isJump    (isJump),
    .taken     (taken),
    .nextPc    (nextPc)
  );
endmodule

// File: rtl/brChecker.sv
module brChecker #(
  parameter bit PipeOut = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] instrWord,
  input logic [15:0] pcIn,
  input logic [15:0] statusIn,
  input logic        isJump,
  input logic        taken,
  input logic [15:0] nextPc
);
  logic primed;
  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R1: a taken branch is always a jump
  p_taken_is_jump_r1: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> isJump);

  // R10: taken targets are even
  p_even_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (nextPc[0] == 1'b0));

  generate
    if (PipeOut) begin : g_seq
      // R7: non-jump words pass the PC through
      p_nonjump_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
        (primed && ($past(instrWord[15:13]) != 3'b001))
          |-> (!isJump && !taken && nextPc == $past(pcIn)));

      // R6: an untaken jump keeps the incremented PC
      p_untaken_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
        (primed && isJump && !taken) |-> (nextPc == $past(pcIn)));

      // R3: condition code 7 always branches
      p_always_taken_r3: assert property (@(posedge clk) disable iff (!rstN)
        (primed && ($past(instrWord[15:10]) == 6'b001111)) |-> taken);

      // R4: code 5 taken exactly when N equals V
      p_ge_rule_r4: assert property (@(posedge clk) disable iff (!rstN)
        (primed && ($past(instrWord[15:10]) == 6'b001101))
          |-> (taken == ($past(statusIn[2]) == $past(statusIn[8]))));

      // R8: outputs are registered jump decode of the prior cycle
      p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
        primed |-> (isJump == ($past(instrWord[15:13]) == 3'b001)));
    end
  endgenerate
endmodule

bind brUnit brChecker #(.PipeOut(PipeOut)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .instrWord (instrWord),
  .pcIn      (pcIn),
  .statusIn  (statusIn),
  .isJump    (isJump),
  .taken     (taken),
  .nextPc    (nextPc)
);

// File: tb/sim_brUnit.sv
module sim_brUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrWord = '0;
  logic [15:0] pcIn = '0;
  logic [15:0] statusIn = '0;
  logic        isJump;
  logic        taken;
  logic [15:0] nextPc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brUnit #(.PipeOut(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .pcIn(pcIn),
    .statusIn(statusIn), .isJump(isJump), .taken(taken), .nextPc(nextPc)
  );

  // vector: instr, pc, status, expected jump, expected taken, requirement number
  localparam int NumVec = 24;
  localparam logic [53:0] Vecs [NumVec] = '{
    {16'h2005, 16'h1000, 16'h0000, 1'b1, 1'b1, 4'd2},  // R2 code0 Z=0
    {16'h2005, 16'h1000, 16'h0002, 1'b1, 1'b0, 4'd2},  // R2 code0 Z=1
    {16'h27FF, 16'h1000, 16'h0002, 1'b1, 1'b1, 4'd2},  // R2 code1 backward -1
    {16'h27FF, 16'h1000, 16'h0000, 1'b1, 1'b0, 4'd2},  // R2 code1 Z=0
    {16'h2810, 16'h2000, 16'h0000, 1'b1, 1'b1, 4'd2},  // R2 code2 C=0
    {16'h2810, 16'h2000, 16'h0001, 1'b1, 1'b0, 4'd6},  // R6 code2 C=1
    {16'h2E00, 16'h0100, 16'h0001, 1'b1, 1'b1, 4'd5},  // R5 code3 most negative, wraps
    {16'h2E00, 16'h0100, 16'h0000, 1'b1, 1'b0, 4'd2},  // R2 code3 C=0
    {16'h31FF, 16'hFF00, 16'h0004, 1'b1, 1'b1, 4'd5},  // R5 code4 most positive, wraps
    {16'h31FF, 16'hFF00, 16'h0000, 1'b1, 1'b0, 4'd3},  // R3 code4 N=0
    {16'h3402, 16'h4000, 16'h0104, 1'b1, 1'b1, 4'd4},  // R4 code5 N=V=1
    {16'h3402, 16'h4000, 16'h0004, 1'b1, 1'b0, 4'd4},  // R4 code5 N!=V
    {16'h3402, 16'h4000, 16'h0000, 1'b1, 1'b1, 4'd4},  // R4 code5 N=V=0
    {16'h3804, 16'h4000, 16'h0100, 1'b1, 1'b1, 4'd4},  // R4 code6 V only
    {16'h3804, 16'h4000, 16'h0104, 1'b1, 1'b0, 4'd4},  // R4 code6 N=V
    {16'h3C00, 16'h5000, 16'hFFFF, 1'b1, 1'b1, 4'd3},  // R3 code7 zero offset
    {16'h3C00, 16'h5000, 16'h0000, 1'b1, 1'b1, 4'd3},  // R3 code7 flags clear
    {16'h4130, 16'h1234, 16'hFFFF, 1'b0, 1'b0, 4'd7},  // R7 move word
    {16'h1004, 16'hABCD, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 format 000
    {16'hE3FF, 16'h0200, 16'h0107, 1'b0, 1'b0, 4'd1},  // R1 format 111
    {16'h2005, 16'h1000, 16'hFEF8, 1'b1, 1'b1, 4'd9},  // R9 code0 with spare bits set
    {16'h2405, 16'h1000, 16'hFEF8, 1'b1, 1'b0, 4'd9},  // R9 code1 with spare bits set
    {16'h3C02, 16'h1001, 16'h0000, 1'b1, 1'b1, 4'd10}, // R10 odd pc, taken
    {16'h2405, 16'h1001, 16'h0000, 1'b1, 1'b0, 4'd6}   // R6 odd pc, untaken
  };

  function automatic logic [15:0] modelNext(input logic [15:0] ins, input logic [15:0] pc,
                                            input logic tk);
    int signed off;
    int sum;
    off = int'(ins[9:0]);
    if (ins[9]) off = off - 1024;
    sum = (int'(pc) + off * 2) & 16'hFFFF;
    sum = sum & 16'hFFFE;
    return tk ? sum[15:0] : pc;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic applyAndCheck(input logic [15:0] ins, input logic [15:0] pc,
                               input logic [15:0] sr, input logic expJ, input logic expT,
                               input string req);
    @(negedge clk);
    instrWord = ins; pcIn = pc; statusIn = sr;
    @(posedge clk);
    @(negedge clk);
    check(req, "isJump", int'(isJump), int'(expJ));
    check(req, "taken", int'(taken), int'(expT));
    check(req, "nextPc", int'(nextPc), int'(modelNext(ins, pc, expT)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state with jump-looking inputs present
    instrWord = 16'h3C10; pcIn = 16'h1234; statusIn = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "reset isJump", int'(isJump), 0);
    check("R8", "reset taken", int'(taken), 0);
    check("R8", "reset nextPc", int'(nextPc), 0);
    rstN = 1'b1;

    for (int i = 0; i < NumVec; i++) begin
      applyAndCheck(Vecs[i][53:38], Vecs[i][37:22], Vecs[i][21:6],
                    Vecs[i][5], Vecs[i][4], $sformatf("R%0d", Vecs[i][3:0]));
    end

    // R8: one-cycle latency: output holds previous result until the next edge
    @(negedge clk);
    instrWord = 16'h3C08; pcIn = 16'h0800; statusIn = 16'h0000;
    @(posedge clk);
    @(negedge clk);
    instrWord = 16'h4130; pcIn = 16'h0900;
    #1;
    check("R8", "latency hold nextPc", int'(nextPc), 16'h0810);
    @(posedge clk);
    @(negedge clk);
    check("R8", "latency update nextPc", int'(nextPc), 16'h0900);
    check("R8", "latency update isJump", int'(isJump), 0);

    // R8: reset in mid-run clears the outputs
    @(negedge clk);
    instrWord = 16'h3C08; pcIn = 16'h0800;
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8", "midrun reset taken", int'(taken), 0);
    check("R8", "midrun reset nextPc", int'(nextPc), 0);
    rstN = 1'b1;

    // R5: back-to-back taken branches with different offsets
    applyAndCheck(16'h3C01, 16'hFFFE, 16'h0000, 1'b1, 1'b1, "R5");
    applyAndCheck(16'h3DFF, 16'h0000, 16'h0000, 1'b1, 1'b1, "R5");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule